// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial protocol engine in front of a small byte-wide storage array. When the engine opens a write transaction it hands over the word address. Each data byte it receives afterwards is captured in a four-slot page latch rather than written to the array. The upper address bits fix the page for the whole transaction. The low two bits act as a column pointer that advances after every byte and wraps inside the page, so a long burst overwrites the slots it filled first.

Nothing reaches the array until the engine reports the stop condition that closes the transaction. At that point the block raises its busy flag and waits for a programmable number of timebase ticks, standing in for the self-timed programming interval (nominally 5 ms, at most 10 ms). It then writes only the slots that the transaction actually filled, one per clock, lowest column first. Busy drops on the same edge as the last array write. While busy, every request from the engine is ignored, which is what lets a host poll for completion. A new start before any stop throws away the latched bytes. The array itself is a register file with a combinational read port.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy and arr_we are low and every array location reads zero.
- R2: wr_start loads the page from wr_addr[6:2] and the first column from wr_addr[1:0]. Each accepted byte goes to the current column, and the column then steps by one, from 3 back to 0, while the page bits stay unchanged.
- R3: When more than four bytes arrive before stop, a later byte replaces the earlier byte held in the same column, and only the final value of each column is committed.
- R4: No array write happens while a transaction is open. The array changes only after the closing stop_pulse.
- R5: A stop_pulse that closes a transaction holding at least one byte raises busy one clock later. With tick held high, busy then stays high for WR_TICKS cycles plus one cycle for each byte to be written.
- R6: Only the columns written in the transaction are written to the array, at address {page, column}. The other locations of the page keep their contents, so a single byte is a page write of length one.
- R7: Commit writes happen one per clock in ascending column order, and arr_we is high only while busy is high.
- R8: Busy falls on the same clock edge as the last array write, and the valid mask is then empty, so the next transaction commits only its own bytes.
- R9: A wr_start that arrives while a transaction is open and not yet stopped discards the latched bytes, and they are never written.
- R10: While busy is high, wr_start, byte_valid and stop_pulse have no effect: nothing opens, nothing is latched, and no further commit follows.
- R11: A stop_pulse that closes a transaction with no bytes does not raise busy and writes nothing.
- R12: The programming interval advances only on clock cycles with tick high, so cycles with tick low lengthen busy by one each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Pulse: a write transaction opens at wr_addr |
| wr_addr | input | 7 | Word address of the write transaction |
| byte_valid | input | 1 | Pulse: a data byte was received |
| byte_data | input | 8 | Received data byte |
| stop_pulse | input | 1 | Pulse: stop condition seen |
| tick | input | 1 | Timebase enable for the programming interval |
| rd_addr | input | 7 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | 7 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress; requests ignored |

## Verification
The assertions take for granted that the protocol engine raises at most one of wr_start, byte_valid and stop_pulse in any clock. The bench drives each event as a separate one-cycle pulse, so it never raises two together. The assertions also rely on the engine's ignored requests during busy being harmless. To test exactly that, the bench fires a full start, byte and stop sequence while busy is high and then checks the array and the busy flag at the ports.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic [1:0] {
      CM_IDLE = 2'd0,
      CM_WAIT = 2'd1,
      CM_PROG = 2'd2
   } cm_state_t;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
   parameter int COL_W  = 2,
   parameter int DATA_W = 8,
   localparam int SLOTS = 1 << COL_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [COL_W-1:0]        load_col_i,
   input  logic                    byte_en_i,
   input  logic [DATA_W-1:0]       byte_i,
   input  logic [SLOTS-1:0]        retire_i,
   output logic [SLOTS-1:0]        mask_o,
   output logic [SLOTS*DATA_W-1:0] slots_o
);
   initial begin
      assert (COL_W >= 1) else $fatal(1, "pwb_page_latch: COL_W must be at least 1");
      assert (DATA_W >= 1) else $fatal(1, "pwb_page_latch: DATA_W must be at least 1");
   end

   logic [COL_W-1:0] col_q;
   logic             take;

   assign take = byte_en_i && !load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      col_q <= '0;
      else if (load_i) col_q <= load_col_i;
      else if (take)   col_q <= col_q + COL_W'(1);
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [DATA_W-1:0] data_q;
      logic              hit;

      assign hit = take && (col_q == COL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   data_q <= '0;
         else if (hit) data_q <= byte_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           mask_o[g] <= 1'b0;
         else if (load_i)      mask_o[g] <= 1'b0;
         else if (hit)         mask_o[g] <= 1'b1;
         else if (retire_i[g]) mask_o[g] <= 1'b0;
      end

      assign slots_o[g*DATA_W +: DATA_W] = data_q;
   end

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> col_q == $past(col_q) + COL_W'(1)); // R2
   AST_RETIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (|retire_i) |-> ((retire_i & ~mask_o) == '0)); // R6
   AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(retire_i)); // R7
endmodule

// File: rtl/pwb_commit_ctrl.sv
module pwb_commit_ctrl
   import pwb_pkg::*;
#(
   parameter int COL_W    = 2,
   parameter int WR_TICKS = 250000,
   parameter bit ASCEND   = 1'b1,
   localparam int SLOTS   = 1 << COL_W,
   localparam int CNT_W   = (WR_TICKS > 1) ? $clog2(WR_TICKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic             tick_i,
   input  logic [SLOTS-1:0] mask_i,
   output logic             busy_o,
   output logic             we_o,
   output logic [COL_W-1:0] idx_o,
   output logic [SLOTS-1:0] retire_o
);
   initial begin
      assert (WR_TICKS >= 1) else $fatal(1, "pwb_commit_ctrl: WR_TICKS must be at least 1");
   end

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_TICKS - 1);

   cm_state_t        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_one;

   if (ASCEND) begin : g_low_first
      always_comb begin
         idx_o = '0;
         for (int i = SLOTS - 1; i >= 0; i--)
            if (mask_i[i]) idx_o = COL_W'(i);
      end
   end else begin : g_high_first
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < SLOTS; i++)
            if (mask_i[i]) idx_o = COL_W'(i);
      end
   end

   assign last_one = ((mask_i & (mask_i - 1'b1)) == '0);
   assign busy_o   = (state_q != CM_IDLE);
   assign we_o     = (state_q == CM_PROG) && (|mask_i);

   always_comb begin
      retire_o = '0;
      if (we_o) retire_o[idx_o] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CM_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            CM_IDLE: begin
               cnt_q <= '0;
               if (launch_i) state_q <= CM_WAIT;
            end
            CM_WAIT: begin
               if (tick_i) begin
                  if (cnt_q == CNT_LAST) begin
                     state_q <= CM_PROG;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            CM_PROG: begin
               if (last_one) state_q <= CM_IDLE;
            end
            default: state_q <= CM_IDLE;
         endcase
      end
   end

   AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> busy_o); // R7
   AST_BUSY_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(we_o)); // R8
   AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CM_WAIT && !tick_i) |=> (state_q == CM_WAIT) && $stable(cnt_q)); // R12

   if (ASCEND) begin : g_order_chk
      AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
         (we_o && $past(we_o)) |-> (idx_o > $past(idx_o))); // R7
   end
endmodule

// File: rtl/pwb_regfile.sv
module pwb_regfile #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 12) else $fatal(1, "pwb_regfile: ADDR_W out of range");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int COL_W    = 2,
   parameter int WR_TICKS = 250000,
   parameter bit ASCEND   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_pulse,
   input  logic              tick,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_waddr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              busy
);
   localparam int SLOTS  = 1 << COL_W;
   localparam int PAGE_W = ADDR_W - COL_W;

   initial begin
      assert (ADDR_W > COL_W) else $fatal(1, "page_write_buffer: ADDR_W must exceed COL_W");
   end

   logic                    start_acc, byte_acc, stop_acc, launch;
   logic                    open_q;
   logic [PAGE_W-1:0]       page_q;
   logic [SLOTS-1:0]        mask, retire;
   logic [SLOTS*DATA_W-1:0] slots;
   logic [COL_W-1:0]        idx;

   assign start_acc = wr_start && !busy;
   assign byte_acc  = byte_valid && !busy && open_q && !wr_start;
   assign stop_acc  = stop_pulse && !busy && open_q && !wr_start && !byte_valid;
   assign launch    = stop_acc && (|mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         page_q <= '0;
      end else if (start_acc) begin
         open_q <= 1'b1;
         page_q <= wr_addr[ADDR_W-1:COL_W];
      end else if (stop_acc) begin
         open_q <= 1'b0;
      end
   end

   pwb_page_latch #(.COL_W(COL_W), .DATA_W(DATA_W)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_acc),
      .load_col_i (wr_addr[COL_W-1:0]),
      .byte_en_i  (byte_acc),
      .byte_i     (byte_data),
      .retire_i   (retire),
      .mask_o     (mask),
      .slots_o    (slots)
   );

   pwb_commit_ctrl #(.COL_W(COL_W), .WR_TICKS(WR_TICKS), .ASCEND(ASCEND)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .tick_i   (tick),
      .mask_i   (mask),
      .busy_o   (busy),
      .we_o     (arr_we),
      .idx_o    (idx),
      .retire_o (retire)
   );

   assign arr_waddr = {page_q, idx};
   assign arr_wdata = slots[idx*DATA_W +: DATA_W];

   pwb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (arr_we),
      .waddr_i (arr_waddr),
      .wdata_i (arr_wdata),
      .raddr_i (rd_addr),
      .rdata_o (rd_data)
   );

   // Input assumption: the protocol engine raises at most one event per clock.
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_start, byte_valid, stop_pulse})); // R10
   AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> !arr_we); // R4
   AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy); // R5
   AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_acc && mask == '0) |=> !busy); // R11
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(page_q)); // R10
   AST_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (mask == '0)); // R8
endmodule

// File: tb/tb_page_write_buffer.sv
`timescale 1ns/1ps
module tb_page_write_buffer;
   localparam int W = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_start = 1'b0;
   logic [6:0] wr_addr = '0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic       stop_pulse = 1'b0;
   logic       tick = 1'b1;
   logic [6:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       arr_we;
   logic [6:0] arr_waddr;
   logic [7:0] arr_wdata;
   logic       busy;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] exp_mem [128];
   int log_a [64];
   int log_d [64];
   int log_n = 0;

   always #10 clk = ~clk;

   page_write_buffer #(.WR_TICKS(W)) dut (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
      .byte_valid(byte_valid), .byte_data(byte_data), .stop_pulse(stop_pulse),
      .tick(tick), .rd_addr(rd_addr), .rd_data(rd_data), .arr_we(arr_we),
      .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .busy(busy)
   );

   always @(negedge clk) begin
      if (rst_n && arr_we && log_n < 64) begin
         log_a[log_n] = int'(arr_waddr);
         log_d[log_n] = int'(arr_wdata);
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_wr(input int k, input int a, input int d, input string req);
      chk(log_a[k] == a && log_d[k] == d, req, log_a[k] * 256 + log_d[k], a * 256 + d);
   endtask

   task automatic mem_cmp(input string req);
      int bad = 0;
      int first = -1;
      for (int a = 0; a < 128; a++) begin
         rd_addr = 7'(a);
         #1;
         if (rd_data !== exp_mem[a]) begin
            bad++;
            if (first < 0) first = a;
         end
      end
      if (first < 0) chk(1'b1, req, 0, 0);
      else begin
         rd_addr = 7'(first);
         #1;
         chk(1'b0, {req, " array"}, first * 256 + int'(rd_data), first * 256 + int'(exp_mem[first]));
      end
   endtask

   task automatic send_start(input logic [6:0] a);
      @(negedge clk); wr_start = 1'b1; wr_addr = a;
      @(negedge clk); wr_start = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d);
      @(negedge clk); byte_valid = 1'b1; byte_data = d;
      @(negedge clk); byte_valid = 1'b0;
   endtask

   task automatic send_stop();
      @(negedge clk); stop_pulse = 1'b1;
      @(negedge clk); stop_pulse = 1'b0;
   endtask

   task automatic wait_idle(output int nb, output bit lastwe);
      int guard = 0;
      nb = 0;
      lastwe = 1'b0;
      while (busy && guard < 2000) begin
         nb++;
         lastwe = arr_we;
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);
      mem_cmp("R1");
   endtask

   task automatic t_single();
      int base, nb; bit lw;
      base = log_n;
      send_start(7'h25); send_byte(8'hA5);
      chk(log_n == base && arr_we == 1'b0, "R4 before stop", log_n - base, 0);
      send_stop();
      wait_idle(nb, lw);
      chk(nb == W + 1, "R5 busy length single", nb, W + 1);
      chk(log_n - base == 1, "R6 single write count", log_n - base, 1);
      chk_wr(base, 'h25, 'hA5, "R6 single write");
      exp_mem[7'h25] = 8'hA5;
      mem_cmp("R6");
   endtask

   task automatic t_page_wrap();
      int base, nb; bit lw;
      base = log_n;
      send_start(7'h1A);
      send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
      chk(log_n == base, "R4 no write while open", log_n - base, 0);
      send_stop();
      wait_idle(nb, lw);
      chk(nb == W + 4, "R5 busy length page", nb, W + 4);
      chk(lw == 1'b1, "R8 busy falls with last write", int'(lw), 1);
      chk(log_n - base == 4, "R2 page write count", log_n - base, 4);
      chk_wr(base + 0, 'h18, 'h33, "R7 order col0");
      chk_wr(base + 1, 'h19, 'h44, "R7 order col1");
      chk_wr(base + 2, 'h1A, 'h11, "R2 col2");
      chk_wr(base + 3, 'h1B, 'h22, "R2 col3");
      exp_mem[7'h18] = 8'h33; exp_mem[7'h19] = 8'h44;
      exp_mem[7'h1A] = 8'h11; exp_mem[7'h1B] = 8'h22;
      mem_cmp("R2");
   endtask

   task automatic t_overflow();
      int base, nb; bit lw;
      base = log_n;
      send_start(7'h40);
      for (int i = 1; i <= 6; i++) send_byte(8'(i));
      send_stop();
      wait_idle(nb, lw);
      chk(log_n - base == 4, "R3 overflow write count", log_n - base, 4);
      chk_wr(base + 0, 'h40, 5, "R3 col0 overwritten");
      chk_wr(base + 1, 'h41, 6, "R3 col1 overwritten");
      exp_mem[7'h40] = 8'd5; exp_mem[7'h41] = 8'd6;
      exp_mem[7'h42] = 8'd3; exp_mem[7'h43] = 8'd4;
      mem_cmp("R3");
   endtask

   task automatic t_partial();
      int base, nb; bit lw;
      base = log_n;
      send_start(7'h7F); send_byte(8'hC1); send_byte(8'hC2);
      send_stop();
      wait_idle(nb, lw);
      chk(nb == W + 2, "R5 busy length two", nb, W + 2);
      chk(log_n - base == 2, "R8 only new bytes written", log_n - base, 2);
      chk_wr(base + 0, 'h7C, 'hC2, "R7 wrapped col0 first");
      chk_wr(base + 1, 'h7F, 'hC1, "R6 col3");
      exp_mem[7'h7C] = 8'hC2; exp_mem[7'h7F] = 8'hC1;
      mem_cmp("R6 partial page");
   endtask

   task automatic t_abort();
      int base, nb; bit lw;
      base = log_n;
      send_start(7'h30); send_byte(8'hE1); send_byte(8'hE2);
      send_start(7'h52); send_byte(8'hF0);
      send_stop();
      wait_idle(nb, lw);
      chk(log_n - base == 1, "R9 discarded bytes", log_n - base, 1);
      chk_wr(base, 'h52, 'hF0, "R9 surviving byte");
      exp_mem[7'h52] = 8'hF0;
      mem_cmp("R9");
   endtask

   task automatic t_busy_ignore();
      int base, nb, hi; bit lw;
      base = log_n;
      send_start(7'h04); send_byte(8'h77);
      send_stop();
      send_start(7'h60); send_byte(8'h99); send_stop();
      wait_idle(nb, lw);
      hi = 0;
      send_byte(8'h55);
      send_stop();
      for (int i = 0; i < W + 4; i++) begin
         if (busy) hi++;
         @(negedge clk);
      end
      chk(hi == 0, "R10 no commit from ignored stop", hi, 0);
      chk(log_n - base == 1, "R10 write count", log_n - base, 1);
      exp_mem[7'h04] = 8'h77;
      mem_cmp("R10");
   endtask

   task automatic t_empty();
      int base, hi;
      base = log_n;
      hi = 0;
      send_start(7'h10);
      send_stop();
      for (int i = 0; i < W + 4; i++) begin
         if (busy) hi++;
         @(negedge clk);
      end
      chk(hi == 0, "R11 busy after empty stop", hi, 0);
      chk(log_n == base, "R11 writes after empty stop", log_n - base, 0);
   endtask

   task automatic t_tick_gate();
      int base, nb, pre; bit lw;
      base = log_n;
      pre = 0;
      send_start(7'h66); send_byte(8'h3C);
      @(negedge clk); stop_pulse = 1'b1; tick = 1'b0;
      @(negedge clk); stop_pulse = 1'b0;
      for (int i = 0; i < 9; i++) begin
         if (busy) pre++;
         @(negedge clk);
      end
      tick = 1'b1;
      wait_idle(nb, lw);
      chk(pre + nb == W + 10, "R12 busy stretched by idle ticks", pre + nb, W + 10);
      chk(log_n - base == 1, "R12 write count", log_n - base, 1);
      exp_mem[7'h66] = 8'h3C;
      mem_cmp("R12");
   endtask

   initial begin
      for (int a = 0; a < 128; a++) exp_mem[a] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_page_wrap();
      t_overflow();
      t_partial();
      t_abort();
      t_busy_ignore();
      t_empty();
      t_tick_gate();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1-all actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule